// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small processor, built as a microcode sequencer. A 64-word control store holds a fixed micro-program. A control address register selects the current word, and a control buffer register holds that word while its control bits drive the datapath. Every micro-step takes two clocks. On the first clock the word at the control address is read and latched into the buffer, and the control outputs take its value. On the second clock the sequencer decides where to go next and loads that address into the control address register.

The next address comes from one of three sources. The first is the current address plus one. The second is the address field of the current word, taken when the word's condition test is true. The third is an entry point computed from the instruction opcode, which dispatches into a four-word micro-routine for each instruction. Conditions can test the zero and carry flags of the ALU, a pending interrupt, and the indirect bit of the instruction. The datapath that consumes the control bits lies outside this block.

Top module: `useq_ctrl`

## Requirements
- R1: While rst_n is low at a rising clock edge, the control buffer and control address are cleared, so ctl_o reads 0. After release, execution starts at word 0.
- R2: The first rising edge after reset release places the control bits of word 0 on ctl_o. After that, ctl_o takes a new word every two clocks and holds it unchanged for the clock between.
- R3: A control word is 24 bits wide. Bits 11:0 are the control bits, bits 14:12 the condition code, bits 20:15 the 6-bit jump address, and bits 23:21 are reserved.
- R4: When the condition is false, the next address is the current address plus one, wrapping modulo 64. Condition code 0 is never true.
- R5: Condition code 1 is always true, so the next address is the word's address field.
- R6: Code 2 jumps when zero_i is 1, and code 3 jumps when carry_i is 1. The inputs are sampled on the address-update clock.
- R7: Code 4 jumps when irq_i is 1.
- R8: Code 5 jumps when ind_i, the indirect bit of the instruction, is 1.
- R9: Code 6 sends control to opcode_i*4 + 16, whatever the address field holds.
- R10: The fetch routine is words 0 to 3, with control bits 001, 002, 004 and 008 hex. Word 3 jumps unconditionally to word 7.
- R11: Word 7 (ctl 010) branches on the indirect bit to the indirect routine, and falls through to word 8 otherwise. The indirect routine is word 10 (ctl 040) then word 11 (ctl 080), which returns to word 8. Word 8 (ctl 020) dispatches on the opcode.
- R12: The interrupt routine is words 12, 13 and 14 (ctl 100, 200, 400), and then returns to word 0.
- R13: The opcode routines are as follows. Opcode 0 runs 801, then goes to interrupt if pending, else runs 000 and returns to fetch. Opcode 1 runs 802, then 804 if zero is set, else 803, then returns to fetch. Opcode 2 runs 805, then 807 if carry is set, else 806, then returns to fetch. Opcode 3 runs 808, then goes to interrupt if pending, else runs 809 and returns to fetch. Unused words jump to word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode_i | input | 2 | Opcode field of the instruction register |
| ind_i | input | 1 | Indirect-addressing bit of the instruction register |
| zero_i | input | 1 | ALU zero flag |
| carry_i | input | 1 | ALU carry flag |
| irq_i | input | 1 | Interrupt request pending |
| ctl_o | output | 12 | Control bits of the word in the control buffer |

## Verification
The assertions assume that rst_n is low for at least one rising edge before it is first released, and that opcode, flags and interrupt inputs carry known values on every address-update clock. The assertions compare each new control address with the inputs sampled on that clock, so the inputs may change at any time. The stimulus drives all inputs on falling edges, sets them before each reset release and holds them constant for a whole scenario, so each path through the micro-program is chosen by a single known input set.

// File: rtl/useq_pkg.sv
// Package: shared widths, the condition code enum, the control-word layout
// and the fixed micro-program. It assumes a 6-bit control address.
package useq_pkg;
    localparam int CTL_W      = 12;
    localparam int COND_W     = 3;
    localparam int UADDR_W    = 6;
    localparam int RSV_W      = 3;
    localparam int OPC_W      = 2;
    localparam int CW_W       = RSV_W + UADDR_W + COND_W + CTL_W;
    localparam int STORE_DEPTH = 1 << UADDR_W;
    localparam int DISP_BASE  = 16;
    localparam int DISP_SHIFT = 2;

    typedef enum logic [COND_W-1:0] {
        C_NEVER    = 3'd0,
        C_ALWAYS   = 3'd1,
        C_ZERO     = 3'd2,
        C_CARRY    = 3'd3,
        C_IRQ      = 3'd4,
        C_INDIR    = 3'd5,
        C_DISPATCH = 3'd6,
        C_RSVD     = 3'd7
    } cond_e;

    // Word layout, msb first: reserved, jump address, condition, control bits (R3)
    typedef struct packed {
        logic [RSV_W-1:0]   rsv;
        logic [UADDR_W-1:0] addr;
        cond_e              cond;
        logic [CTL_W-1:0]   ctl;
    } cword_t;

    function automatic cword_t mk(input logic [CTL_W-1:0] c, input cond_e k,
                                  input logic [UADDR_W-1:0] a);
        cword_t w;
        w.rsv  = '0;
        w.addr = a;
        w.cond = k;
        w.ctl  = c;
        return w;
    endfunction

    // Micro-program contents, one word per control address
    function automatic cword_t program_word(input int unsigned idx);
        case (idx)
            0:  return mk(12'h001, C_NEVER,    6'd0);
            1:  return mk(12'h002, C_NEVER,    6'd0);
            2:  return mk(12'h004, C_NEVER,    6'd0);
            3:  return mk(12'h008, C_ALWAYS,   6'd7);
            7:  return mk(12'h010, C_INDIR,    6'd10);
            8:  return mk(12'h020, C_DISPATCH, 6'd0);
            10: return mk(12'h040, C_NEVER,    6'd0);
            11: return mk(12'h080, C_ALWAYS,   6'd8);
            12: return mk(12'h100, C_NEVER,    6'd0);
            13: return mk(12'h200, C_NEVER,    6'd0);
            14: return mk(12'h400, C_ALWAYS,   6'd0);
            16: return mk(12'h801, C_IRQ,      6'd12);
            17: return mk(12'h000, C_ALWAYS,   6'd0);
            20: return mk(12'h802, C_ZERO,     6'd23);
            21: return mk(12'h803, C_ALWAYS,   6'd0);
            23: return mk(12'h804, C_ALWAYS,   6'd0);
            24: return mk(12'h805, C_CARRY,    6'd27);
            25: return mk(12'h806, C_ALWAYS,   6'd0);
            27: return mk(12'h807, C_ALWAYS,   6'd0);
            28: return mk(12'h808, C_IRQ,      6'd12);
            29: return mk(12'h809, C_ALWAYS,   6'd0);
            default: return mk(12'h000, C_ALWAYS, 6'd0);
        endcase
    endfunction
endpackage

// File: rtl/useq_store.sv
// Module: control store. It is a read-only array built from the package
// micro-program and read without a clock. The caller registers the read word.
module useq_store
    import useq_pkg::*;
(
    input  logic [UADDR_W-1:0] rd_addr,
    output cword_t             rd_word
);
    cword_t rom [STORE_DEPTH];

    // Fill every location from the program function
    for (genvar i = 0; i < STORE_DEPTH; i++) begin : g_rom
        assign rom[i] = program_word(i);
    end

    // Asynchronous read of the addressed word
    assign rd_word = rom[rd_addr];
endmodule

// File: rtl/useq_cond.sv
// Module: condition evaluator. It tests the condition code against the flags
// and flags a dispatch. It assumes the flag inputs are stable on the update clock.
module useq_cond
    import useq_pkg::*;
(
    input  cond_e cond,
    input  logic  zero,
    input  logic  carry,
    input  logic  irq,
    input  logic  indir,
    output logic  take,
    output logic  dispatch
);
    // Decode the condition into a jump-or-sequence decision
    always_comb begin
        take     = 1'b0;
        dispatch = 1'b0;
        case (cond)
            C_ALWAYS:   take = 1'b1;
            C_ZERO:     take = zero;
            C_CARRY:    take = carry;
            C_IRQ:      take = irq;
            C_INDIR:    take = indir;
            C_DISPATCH: dispatch = 1'b1;
            default:    take = 1'b0;
        endcase
    end
endmodule

// File: rtl/useq_next.sv
// Module: next-address multiplexer. It picks between the incremented address,
// the jump address field and the opcode entry point. It assumes that at most
// one of take and dispatch matters, with dispatch having priority.
module useq_next
    import useq_pkg::*;
(
    input  logic [UADDR_W-1:0] car,
    input  logic [UADDR_W-1:0] jump_addr,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               take,
    input  logic               dispatch,
    output logic [UADDR_W-1:0] next_addr
);
    localparam logic [UADDR_W-1:0] BASE = UADDR_W'(DISP_BASE);

    logic [UADDR_W-1:0] entry;

    // Opcode-mapped entry point of the instruction routine
    assign entry = BASE + (UADDR_W'(opcode) << DISP_SHIFT);

    // Three-way choice of the next control address
    always_comb begin
        if (dispatch)  next_addr = entry;
        else if (take) next_addr = jump_addr;
        else           next_addr = car + 1'b1;
    end
endmodule

// File: rtl/useq_ctrl.sv
// Module: top of the sequencer. It holds the control address register, the
// control buffer register and a phase bit. Phase 0 latches the store word and
// phase 1 loads the next address. It assumes a synchronous active-low reset.
module useq_ctrl
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             ind_i,
    input  logic             zero_i,
    input  logic             carry_i,
    input  logic             irq_i,
    output logic [CTL_W-1:0] ctl_o
);
    logic               phase;
    logic [UADDR_W-1:0] car;
    cword_t             cbr;
    cword_t             rd_word;
    logic               take;
    logic               dispatch;
    logic [UADDR_W-1:0] next_addr;

    useq_store u_store (
        .rd_addr (car),
        .rd_word (rd_word)
    );

    useq_cond u_cond (
        .cond     (cbr.cond),
        .zero     (zero_i),
        .carry    (carry_i),
        .irq      (irq_i),
        .indir    (ind_i),
        .take     (take),
        .dispatch (dispatch)
    );

    useq_next u_next (
        .car       (car),
        .jump_addr (cbr.addr),
        .opcode    (opcode_i),
        .take      (take),
        .dispatch  (dispatch),
        .next_addr (next_addr)
    );

    // Alternate between the read phase and the address-update phase
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    // Latch the addressed store word into the buffer in the read phase
    always_ff @(posedge clk) begin
        if (!rst_n)      cbr <= '0;
        else if (!phase) cbr <= rd_word;
    end

    // Load the chosen next address in the update phase
    always_ff @(posedge clk) begin
        if (!rst_n)     car <= '0;
        else if (phase) car <= next_addr;
    end

    // Control outputs come straight from the buffer
    assign ctl_o = cbr.ctl;

    // R1: reset clears buffer and address
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (ctl_o == '0 && car == '0));

    // R2: outputs hold through the update phase
    p_hold_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase |=> (ctl_o == $past(ctl_o)));

    // R2: the address does not move in the read phase
    p_car_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> (car == $past(car)));

    // R4: a never condition advances by one
    p_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && cbr.cond == C_NEVER) |=> (car == UADDR_W'($past(car) + 1'b1)));

    // R5: an always condition takes the address field
    p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && cbr.cond == C_ALWAYS) |=> (car == $past(cbr.addr)));

    // R6: the zero condition follows the sampled flag
    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && cbr.cond == C_ZERO) |=>
        (car == ($past(zero_i) ? $past(cbr.addr) : UADDR_W'($past(car) + 1'b1))));

    // R7: the interrupt condition follows the request
    p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && cbr.cond == C_IRQ) |=>
        (car == ($past(irq_i) ? $past(cbr.addr) : UADDR_W'($past(car) + 1'b1))));

    // R9: dispatch lands on the opcode entry point
    p_dispatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && cbr.cond == C_DISPATCH) |=>
        (car == UADDR_W'(DISP_BASE + 4 * $past(opcode_i))));
endmodule

// File: tb/useq_ctrl_tb.sv
module useq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  opcode_i = 2'd0;
    logic        ind_i = 1'b0;
    logic        zero_i = 1'b0;
    logic        carry_i = 1'b0;
    logic        irq_i = 1'b0;
    logic [11:0] ctl_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    useq_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode_i (opcode_i),
        .ind_i    (ind_i),
        .zero_i   (zero_i),
        .carry_i  (carry_i),
        .irq_i    (irq_i),
        .ctl_o    (ctl_o)
    );

    always #5 clk = ~clk;

    task automatic check(input logic [11:0] exp, input string req);
        checks++;
        if (ctl_o !== exp) begin
            errors++;
            $display("FAIL %s: ctl_o=%h expected %h", req, ctl_o, exp);
        end
    endtask

    // R1: hold reset across an edge, check the cleared output, then release
    task automatic do_reset(input logic [1:0] op, input logic ind, input logic z,
                            input logic c, input logic irq);
        rst_n = 1'b0;
        opcode_i = op; ind_i = ind; zero_i = z; carry_i = c; irq_i = irq;
        @(negedge clk);
        @(negedge clk);
        check(12'h000, "R1");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R2: check the shown word, check it is held a clock later, then advance
    task automatic step(input logic [11:0] exp, input string req);
        check(exp, req);
        @(negedge clk);
        check(exp, "R2");
        @(negedge clk);
    endtask

    // R10 and R11: fetch words and the execute entry
    task automatic fetch_prefix();
        step(12'h001, "R10");
        step(12'h002, "R10 R4");
        step(12'h004, "R10 R4");
        step(12'h008, "R10");
        step(12'h010, "R11 R5");
    endtask

    // Opcode 0 without interrupt: R13 R9 R7
    task automatic t_op0_plain();
        do_reset(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        fetch_prefix();
        step(12'h020, "R11 R8");
        step(12'h801, "R9 R13");
        step(12'h000, "R7 R13");
        step(12'h001, "R13 R5");
    endtask

    // Opcode 0 with interrupt: R12 R7
    task automatic t_op0_irq();
        do_reset(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        fetch_prefix();
        step(12'h020, "R11");
        step(12'h801, "R9");
        step(12'h100, "R7 R12");
        step(12'h200, "R12");
        step(12'h400, "R12");
        step(12'h001, "R12");
    endtask

    // Indirect path with opcode 1, zero set: R8 R6
    task automatic t_indirect_zero();
        do_reset(2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
        fetch_prefix();
        step(12'h040, "R8 R11");
        step(12'h080, "R11");
        step(12'h020, "R11");
        step(12'h802, "R9 R13");
        step(12'h804, "R6");
        step(12'h001, "R13");
    endtask

    // Opcode 1, zero clear: R6 falls through
    task automatic t_op1_nozero();
        do_reset(2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        fetch_prefix();
        step(12'h020, "R11");
        step(12'h802, "R9");
        step(12'h803, "R6");
        step(12'h001, "R13");
    endtask

    // Opcode 2 with and without carry: R6 R13
    task automatic t_op2(input logic c);
        do_reset(2'd2, 1'b0, 1'b1, c, 1'b0);
        fetch_prefix();
        step(12'h020, "R11");
        step(12'h805, "R9");
        step(c ? 12'h807 : 12'h806, "R6");
        step(12'h001, "R13");
    endtask

    // Opcode 3 with and without interrupt: R7 R13
    task automatic t_op3(input logic irq);
        do_reset(2'd3, 1'b0, 1'b0, 1'b0, irq);
        fetch_prefix();
        step(12'h020, "R11");
        step(12'h808, "R9");
        step(irq ? 12'h100 : 12'h809, "R7");
        if (!irq) step(12'h001, "R13");
    endtask

    // R1: reset in mid-routine restarts at fetch
    task automatic t_mid_reset();
        do_reset(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        step(12'h001, "R1");
        step(12'h002, "R1");
        do_reset(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        step(12'h001, "R1");
    endtask

    initial begin
        t_op0_plain();
        t_op0_irq();
        t_indirect_zero();
        t_op1_nozero();
        t_op2(1'b1);
        t_op2(1'b0);
        t_op3(1'b0);
        t_op3(1'b1);
        t_mid_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: ctl_o=%h expected finish", ctl_o);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule